// File: doc/BRIEF.md
# ACPI Fixed Power-Management Event Block

This block holds the fixed power-management event registers of a system controller: a 16-bit event status word, a 16-bit event enable word, a 16-bit control word and a free-running 24-bit power-management timer. Software reaches them through a simple word-wide register port decoded by a 6-bit offset. A level system-control interrupt (`sci`) goes high whenever an enabled event is pending in one of the four interrupt-capable status positions.

A separate two-byte power-management command port lets firmware turn the SCI-enable control bit on or off by writing a command code. When the SMI-enable configuration input is high, it also raises a one-cycle SMI pulse on every command write. The block also takes a power-button strobe and a timer tick-enable, which stands in for the real timer clock. A control write with the sleep-go bit set is decoded by a small sleep sequencer. The sequencer has three states: `SLP_RUN` (idle), `SLP_OFF` (soft power-off requested) and `SLP_SUSP` (suspend requested). Its transitions are:
- From `SLP_RUN` it moves to `SLP_OFF` when the sleep type is 0.
- From `SLP_RUN` it moves to `SLP_SUSP` when the sleep type is 1.
- From `SLP_RUN` it stays in `SLP_RUN` for any other type.
- From `SLP_OFF` or `SLP_SUSP` it returns to `SLP_RUN` after one cycle, or re-enters a request state if another sleep-go write arrives in that cycle.

The outputs `sleep_req` and `sleep_type` are driven from this state.

Top module: `pm_event_regs`

## Requirements
- R1: The timer advances by one on every clock with `tick_en` high and wraps at 24 bits. A register read at offset 0x08 returns `{8'h00, timer}`.
- R2: After reset, every register and the timer are zero, and `sci`, `smi` and `sleep_req` are low.
- R3: Status bit 0 sets, and stays set, whenever the timer steps from a value whose low OVF_SHIFT bits are all ones, i.e. it crosses a multiple of 2^OVF_SHIFT. The default OVF_SHIFT of 23 gives a step of 0x800000.
- R4: Offset 0x00 reads the status word. Writing it clears each bit written as 1. A bit set by an event in the same cycle stays set.
- R5: Offset 0x02 (enable) is written and read back directly. Offset 0x04 (control) stores the written value with bit 13 forced to 0.
- R6: A control write with bit 13 set decodes bits 12:10 as the sleep type. Type 0 gives a one-cycle `sleep_req` with `sleep_type`=0 on the next cycle. Type 1 gives the same with `sleep_type`=1 and also sets status bits 15 and 8. Types 2 to 7 give no request. `sleep_type` reads 0 when no request is shown.
- R7: `sci` is high exactly when (status AND enable) has bit 0, 5, 8 or 10 set.
- R8: On the command port, `apm_sel`=0 selects the command byte and `apm_sel`=1 selects a plain read/write status byte; both read back their last written value. Writing command 0xF1 sets control bit 0, writing 0xF0 clears it, and other codes leave it alone.
- R9: Every command-byte write with `smi_cfg_en` high produces a one-cycle `smi` pulse on the next cycle. Otherwise `smi` stays low.
- R10: A `pwr_btn` strobe sets status bit 8 only while enable bit 8 is set.
- R11: Reads of any offset other than 0x00, 0x02, 0x04 and 0x08 return 0. Writes to such offsets change no register.
- R12: When a command write and a control-register write fall in the same cycle, the command decides control bit 0 (0xF1 gives 1, 0xF0 gives 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer advance enable |
| pwr_btn | input | 1 | Power-button event strobe |
| smi_cfg_en | input | 1 | Allow SMI pulses on command writes |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| apm_wr | input | 1 | Command port write strobe |
| apm_sel | input | 1 | 0 selects the command byte, 1 the status byte |
| apm_wdata | input | 8 | Command port write data |
| apm_rdata | output | 8 | Command port read data for `apm_sel` |
| sci | output | 1 | Level system-control interrupt |
| smi | output | 1 | One-cycle SMI pulse |
| sleep_req | output | 1 | One-cycle sleep request |
| sleep_type | output | 3 | Decoded sleep type while `sleep_req` is high |

## Verification
The two pairs of functions that can fall in the same cycle are handled the same way.
- **Timer crossing and status clear.** The bench watches its own timer model. It issues a write-1-to-clear of status bit 0 in exactly the cycle where the timer steps across an overflow boundary. The bit must read back as set, because the event wins over the clear.
- **Command byte and control write.** The bench writes a control value whose bit 0 disagrees with an 0xF0 or 0xF1 command written in the same cycle. Control bit 0 must follow the command.

A behavioural model in the bench predicts every output and read value on each clock. Random mixed traffic then provokes further overlaps.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam logic [5:0]  OFS_STS   = 6'h00;
    localparam logic [5:0]  OFS_EN    = 6'h02;
    localparam logic [5:0]  OFS_CTL   = 6'h04;
    localparam logic [5:0]  OFS_TMR   = 6'h08;
    localparam logic [15:0] SCI_MASK  = 16'h0521;
    localparam int          STS_TMR   = 0;
    localparam int          STS_BTN   = 8;
    localparam int          STS_WAKE  = 15;
    localparam int          CTL_SCIEN = 0;
    localparam int          CTL_GO    = 13;
    localparam int          CTL_TYPLO = 10;
    localparam logic [7:0]  CMD_ON    = 8'hF1;
    localparam logic [7:0]  CMD_OFF   = 8'hF0;

    typedef enum logic [1:0] {
        SLP_RUN  = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_SUSP = 2'd2
    } slp_state_t;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W     = 24,
    parameter int OVF_SHIFT = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [TMR_W-1:0] count_o,
    output logic             cross_o
);
    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (tick_en) count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;
    assign cross_o = tick_en & (&count_q[OVF_SHIFT-1:0]);

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> count_q == TMR_W'($past(count_q) + 1'b1)); // R1
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(count_q)); // R1
endmodule

// File: rtl/pm_sleep_fsm.sv
module pm_sleep_fsm
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [2:0] typ_i,
    output logic       sleep_req_o,
    output logic [2:0] sleep_type_o
);
    slp_state_t state_q, state_d;

    always_comb begin
        state_d = SLP_RUN;
        if (go_i) begin
            unique case (typ_i)
                3'd0:    state_d = SLP_OFF;
                3'd1:    state_d = SLP_SUSP;
                default: state_d = SLP_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLP_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLP_OFF:  begin sleep_req_o = 1'b1; sleep_type_o = 3'd0; end
            SLP_SUSP: begin sleep_req_o = 1'b1; sleep_type_o = 3'd1; end
            default:  begin sleep_req_o = 1'b0; sleep_type_o = 3'd0; end
        endcase
    end

    AST_SLP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req_o && !go_i) |=> !sleep_req_o); // R6
    AST_SLP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && typ_i > 3'd1) |=> !sleep_req_o); // R6
endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port
    import pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic       sel_i,
    input  logic [7:0] wdata_i,
    input  logic       smi_cfg_i,
    output logic [7:0] rdata_o,
    output logic       sci_on_o,
    output logic       sci_off_o,
    output logic       smi_o
);
    logic [7:0] cmd_q, aux_q;
    logic       smi_q;
    logic       cmd_wr;

    assign cmd_wr = wr_i & ~sel_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            aux_q <= '0;
            smi_q <= 1'b0;
        end else begin
            if (cmd_wr)          cmd_q <= wdata_i;
            if (wr_i && sel_i)   aux_q <= wdata_i;
            smi_q <= cmd_wr & smi_cfg_i;
        end
    end

    assign rdata_o   = sel_i ? aux_q : cmd_q;
    assign sci_on_o  = cmd_wr && (wdata_i == CMD_ON);
    assign sci_off_o = cmd_wr && (wdata_i == CMD_OFF);
    assign smi_o     = smi_q;

    AST_SMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && smi_cfg_i) |=> smi_o); // R9
    AST_SMI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && smi_cfg_i) |=> !smi_o); // R9
endmodule

// File: rtl/pm_event_regs.sv
module pm_event_regs
    import pm_pkg::*;
#(
    parameter int OVF_SHIFT = 23
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        pwr_btn,
    input  logic        smi_cfg_en,
    input  logic        reg_wr,
    input  logic [5:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        apm_wr,
    input  logic        apm_sel,
    input  logic [7:0]  apm_wdata,
    output logic [7:0]  apm_rdata,
    output logic        sci,
    output logic        smi,
    output logic        sleep_req,
    output logic [2:0]  sleep_type
);
    localparam int TMR_W = 24;
    localparam int REG_W = 16;

    logic [REG_W-1:0] sts_q, en_q, ctl_q;
    logic [REG_W-1:0] sts_d, ctl_d, sts_set, sts_clr;
    logic [TMR_W-1:0] tmr;
    logic             tmr_cross, sci_on, sci_off;
    logic             wr_sts, wr_en, wr_ctl, go;
    logic [2:0]       go_typ;

    pm_timer #(.TMR_W(TMR_W), .OVF_SHIFT(OVF_SHIFT)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .count_o(tmr), .cross_o(tmr_cross)
    );

    pm_apm_port i_apm (
        .clk(clk), .rst_n(rst_n), .wr_i(apm_wr), .sel_i(apm_sel),
        .wdata_i(apm_wdata), .smi_cfg_i(smi_cfg_en), .rdata_o(apm_rdata),
        .sci_on_o(sci_on), .sci_off_o(sci_off), .smi_o(smi)
    );

    assign wr_sts = reg_wr && (reg_addr == OFS_STS);
    assign wr_en  = reg_wr && (reg_addr == OFS_EN);
    assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
    assign go     = wr_ctl && reg_wdata[CTL_GO];
    assign go_typ = reg_wdata[CTL_TYPLO +: 3];

    pm_sleep_fsm i_sleep (
        .clk(clk), .rst_n(rst_n), .go_i(go), .typ_i(go_typ),
        .sleep_req_o(sleep_req), .sleep_type_o(sleep_type)
    );

    always_comb begin
        sts_set = '0;
        sts_set[STS_TMR] = tmr_cross;
        sts_set[STS_BTN] = pwr_btn & en_q[STS_BTN];
        if (go && go_typ == 3'd1) begin
            sts_set[STS_WAKE] = 1'b1;
            sts_set[STS_BTN]  = 1'b1;
        end
        sts_clr = wr_sts ? reg_wdata : '0;
        sts_d   = (sts_q & ~sts_clr) | sts_set;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl) begin
            ctl_d         = reg_wdata;
            ctl_d[CTL_GO] = 1'b0;
        end
        if (sci_on)  ctl_d[CTL_SCIEN] = 1'b1;
        if (sci_off) ctl_d[CTL_SCIEN] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
            ctl_q <= '0;
        end else begin
            sts_q <= sts_d;
            ctl_q <= ctl_d;
            if (wr_en) en_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STS: reg_rdata = {16'h0, sts_q};
            OFS_EN:  reg_rdata = {16'h0, en_q};
            OFS_CTL: reg_rdata = {16'h0, ctl_q};
            OFS_TMR: reg_rdata = {8'h0, tmr};
            default: reg_rdata = '0;
        endcase
    end

    assign sci = |(sts_q & en_q & SCI_MASK);

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_cross |=> sts_q[STS_TMR]); // R3
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q)); // R11
    AST_SCIEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sci_on |=> ctl_q[CTL_SCIEN]); // R12
    AST_SCIEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sci_off |=> !ctl_q[CTL_SCIEN]); // R8
    AST_GO_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> !ctl_q[CTL_GO]); // R5
endmodule

// File: tb/test_pm_event_regs.sv
module test_pm_event_regs;
    localparam int OVF = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 0, pwr_btn = 0, smi_cfg_en = 0;
    logic        reg_wr = 0;
    logic [5:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        apm_wr = 0, apm_sel = 0;
    logic [7:0]  apm_wdata = 0;
    logic [7:0]  apm_rdata;
    logic        sci, smi, sleep_req;
    logic [2:0]  sleep_type;

    int checks = 0, failures = 0;
    bit done = 0;
    string cur_req = "R2";

    int m_tmr, m_sts, m_en, m_ctl, m_cmd, m_aux, m_smi, m_req, m_typ;

    always #2.5 clk = ~clk;

    pm_event_regs #(.OVF_SHIFT(OVF)) i_pm_event_regs (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwr_btn(pwr_btn),
        .smi_cfg_en(smi_cfg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .apm_wr(apm_wr),
        .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
        .sci(sci), .smi(smi), .sleep_req(sleep_req), .sleep_type(sleep_type)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int model_read(input int a);
        case (a)
            0: return m_sts;
            2: return m_en;
            4: return m_ctl;
            8: return m_tmr;
            default: return 0;
        endcase
    endfunction

    task automatic compare_all();
        chk("R7", "sci", sci, ((m_sts & m_en & 'h0521) != 0));
        chk("R9", "smi", smi, m_smi);
        chk("R6", "sleep_req", sleep_req, m_req);
        chk("R6", "sleep_type", sleep_type, m_typ);
        chk(cur_req, "reg_rdata", reg_rdata, model_read(int'(reg_addr)));
        chk("R8", "apm_rdata", apm_rdata, apm_sel ? m_aux : m_cmd);
    endtask

    task automatic step();
        int set, clr, n_ctl, n_sts, typ;
        set = 0; clr = 0; n_ctl = m_ctl;
        if (tick_en && ((m_tmr & ((1 << OVF) - 1)) == ((1 << OVF) - 1))) set |= 1;
        if (pwr_btn && m_en[8]) set |= 'h100;
        if (reg_wr && reg_addr == 0) clr = reg_wdata;
        m_req = 0; m_typ = 0;
        if (reg_wr && reg_addr == 4) begin
            n_ctl = reg_wdata & 'hDFFF;
            if (reg_wdata[13]) begin
                typ = (reg_wdata >> 10) & 7;
                if (typ == 0) m_req = 1;
                if (typ == 1) begin m_req = 1; m_typ = 1; set |= 'h8100; end
            end
        end
        m_smi = 0;
        if (apm_wr && !apm_sel) begin
            m_cmd = apm_wdata;
            if (apm_wdata == 8'hF1) n_ctl |= 1;
            if (apm_wdata == 8'hF0) n_ctl &= ~1;
            m_smi = smi_cfg_en;
        end
        if (apm_wr && apm_sel) m_aux = apm_wdata;
        n_sts = ((m_sts & ~clr) | set) & 'hFFFF;
        if (reg_wr && reg_addr == 2) m_en = reg_wdata;
        if (tick_en) m_tmr = (m_tmr + 1) & 'hFFFFFF;
        m_sts = n_sts;
        m_ctl = n_ctl;
        @(posedge clk);
        #1;
        compare_all();
        reg_wr = 0; apm_wr = 0; pwr_btn = 0;
    endtask

    task automatic wreg(input int a, input int d);
        reg_wr = 1; reg_addr = a[5:0]; reg_wdata = d[15:0];
        step();
    endtask

    task automatic wapm(input bit s, input int d);
        apm_wr = 1; apm_sel = s; apm_wdata = d[7:0];
        step();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_tmr = 0; m_sts = 0; m_en = 0; m_ctl = 0; m_cmd = 0; m_aux = 0;
        m_smi = 0; m_req = 0; m_typ = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R2: reset state
        cur_req = "R2";
        compare_all();
        for (int a = 0; a <= 8; a += 2) begin
            reg_addr = a[5:0];
            #0.1;
            chk("R2", "reset reg", reg_rdata, 0);
        end
        reg_addr = 0;

        // R1: timer advance and read at 0x08
        cur_req = "R1";
        reg_addr = 6'h08;
        tick_en = 1;
        for (int i = 0; i < 40; i++) step();
        tick_en = 0;
        for (int i = 0; i < 3; i++) step();

        // R3 and R7: overflow crossing sets bit 0, SCI when enabled
        cur_req = "R3";
        wreg(2, 'h0001);
        reg_addr = 0;
        tick_en = 1;
        for (int i = 0; i < 100; i++) step();
        tick_en = 0;
        chk("R3", "status bit0 after crossing", reg_rdata[0], 1);
        chk("R7", "sci with timer event", sci, 1);

        // R4: clear, then clear in the crossing cycle
        cur_req = "R4";
        wreg(0, 'h0001);
        chk("R4", "bit0 cleared", reg_rdata[0], 0);
        tick_en = 1;
        while ((m_tmr & ((1 << OVF) - 1)) != ((1 << OVF) - 1)) step();
        wreg(0, 'h0001);
        tick_en = 0;
        reg_addr = 0;
        #0.1;
        chk("R4", "set beats clear", reg_rdata[0], 1);
        wreg(0, 'hFFFF);

        // R5: enable and control storage
        cur_req = "R5";
        wreg(2, 'hA5A5); reg_addr = 2; step();
        wreg(4, 'h1C03); reg_addr = 4; step();
        wreg(4, 'h2803); reg_addr = 4; step();
        chk("R5", "ctl bit13 dropped", reg_rdata, 'h0803);
        chk("R6", "type 2 gives no request", sleep_req, 0);

        // R6: sleep types 0 and 1
        cur_req = "R6";
        wreg(4, 'h2000);
        chk("R6", "type0 request", sleep_req, 1);
        step();
        wreg(2, 'h0100);
        wreg(4, 'h2400);
        chk("R6", "type1 request", sleep_type, 1);
        reg_addr = 0;
        step();
        chk("R6", "wake+button status", reg_rdata & 'h8100, 'h8100);
        chk("R7", "sci from button", sci, 1);
        wreg(0, 'hFFFF);

        // R10: power button gated by enable bit 8
        cur_req = "R10";
        wreg(2, 'h0000);
        pwr_btn = 1; step();
        chk("R10", "button masked", reg_rdata[8], 0);
        wreg(2, 'h0100);
        pwr_btn = 1; step();
        chk("R10", "button taken", reg_rdata[8], 1);
        wreg(0, 'h0100);

        // R8 / R9: command port
        cur_req = "R8";
        reg_addr = 4;
        wreg(4, 'h0000); reg_addr = 4;
        smi_cfg_en = 0;
        wapm(0, 'hF1); chk("R8", "F1 sets sci enable", reg_rdata[0], 1);
        wapm(0, 'h55); chk("R8", "other code keeps", reg_rdata[0], 1);
        wapm(0, 'hF0); chk("R8", "F0 clears sci enable", reg_rdata[0], 0);
        smi_cfg_en = 1;
        wapm(0, 'h12); chk("R9", "smi pulse", smi, 1);
        step();        chk("R9", "smi one cycle", smi, 0);
        wapm(1, 'h3C); apm_sel = 1; step();
        chk("R9", "status byte write no smi", smi, 0);
        apm_sel = 0;
        smi_cfg_en = 0;

        // R11: undecoded offsets
        cur_req = "R11";
        wreg(6, 'hFFFF); wreg(10, 'hFFFF); wreg(1, 'hFFFF);
        reg_addr = 6'h3E; step();
        chk("R11", "undecoded read", reg_rdata, 0);

        // R12: command and control write in the same cycle
        cur_req = "R12";
        reg_wr = 1; reg_addr = 4; reg_wdata = 16'h0001;
        apm_wr = 1; apm_sel = 0; apm_wdata = 8'hF0;
        step();
        chk("R12", "F0 over control write", reg_rdata[0], 0);
        reg_wr = 1; reg_addr = 4; reg_wdata = 16'h0000;
        apm_wr = 1; apm_sel = 0; apm_wdata = 8'hF1;
        step();
        chk("R12", "F1 over control write", reg_rdata[0], 1);

        // mixed random traffic
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            tick_en = r[0];
            pwr_btn = r[1];
            smi_cfg_en = r[2];
            reg_wr = r[3] & r[4];
            reg_addr = (r[7:5] == 0) ? 6'($urandom) : 6'({r[10:8], 1'b0});
            reg_wdata = 16'($urandom);
            if (reg_addr == 4 && r[11]) reg_wdata[13] = 1'b0;
            apm_wr = r[12] & r[13];
            apm_sel = r[14];
            apm_wdata = r[15] ? (r[16] ? 8'hF1 : 8'hF0) : 8'($urandom);
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule